// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers seven event pulses (timer, error, low alert, high alert, idle, receive and transmit) into a register of sticky flags. The host changes that register through a masked write. The top data bit of the write chooses the action: when it is 1, the marked flags are set, and when it is 0, the marked flags are cleared. Flags that the write does not mark keep their value.

A separate enable register decides which flags contribute to one combined request. The request is the OR over all flags, each gated by its enable bit. The host can read the request back as a status bit. The top bit of the enable register selects the polarity of the single interrupt pin.

The idle flag has its own qualification. It is set when a running command ends and returns to idle, or when an unknown command code falls back to idle. It is not set when the host itself issues the idle command. The host port is a plain register port: a write happens in the cycle in which `wr_en` is high, and the read data is combinational from `rd_sel`. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the flag register reads 0x14 and the enable register reads 0x80. The status register (select 2) reads 0x00 and `irq_pin` is 1.
- R2: A high pulse on `evt_in[i]` sets flag i at the next clock edge, and the flag stays set until the host clears it. The bit positions are timer 0, error 1, low alert 2, high alert 3, idle 4, receive 5 and transmit 6.
- R3: A write to select 0 with data bit 7 = 1 sets every flag whose data bit (6..0) is 1. Every other flag is left unchanged.
- R4: A write to select 0 with data bit 7 = 0 clears every flag whose data bit (6..0) is 1. Every other flag is left unchanged, and writing 0x7F clears all seven flags.
- R5: When a flag's event arrives in the same cycle as a host clear of that flag, the event wins and the flag stays set.
- R6: The combined request is the OR over the flags, each ANDed with the enable bit at the same position. It reads as bit 0 of select 2, and bits 7..1 of select 2 read 0.
- R7: When enable bit 7 is 0, `irq_pin` equals the combined request. When enable bit 7 is 1, `irq_pin` is the complement of the combined request.
- R8: The idle flag (bit 4) is set by `evt_in[4]` (a command ended) or by `cmd_unknown`. Neither sets it in a cycle in which `host_idle_cmd` is 1.
- R9: Reading select 0 always returns bit 7 as 0.
- R10: A write to select 1 stores all 8 data bits in the enable register, and the byte reads back at select 1. A write to select 2 or 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 = flags, 1 = enables, 2 and 3 = no register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read source: 0 = flags, 1 = enables, 2 = status, 3 = zero |
| rd_data | output | 8 | Combinational read data |
| evt_in | input | 7 | Event pulses, one per flag position |
| cmd_unknown | input | 1 | An unknown command code fell back to idle |
| host_idle_cmd | input | 1 | The host issued the idle command in this cycle |
| irq_pin | output | 1 | Interrupt output, polarity set by enable bit 7 |

## Verification
A flag cell that holds a wrong value shows up at the flag read port in the cycle after the offending edge. It also shows up on `irq_pin` and in the status bit as soon as the enable for that cell is set, because the request path has no registers. An inverted set/clear selector, or a mask that spills into unmarked flags, changes bits that the write did not mark, and the very next read of select 0 exposes it. A reversed priority between event and clear, or an idle flag that host commands can set, appears one cycle after the colliding inputs.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NUM_FLAGS = 7;
  localparam int REG_W     = NUM_FLAGS + 1;
  localparam int SEL_W     = 2;

  // Flag positions are fixed because host software decodes them.
  localparam int BIT_TIMER = 0;
  localparam int BIT_ERROR = 1;
  localparam int BIT_LOW   = 2;
  localparam int BIT_HIGH  = 3;
  localparam int BIT_IDLE  = 4;
  localparam int BIT_RX    = 5;
  localparam int BIT_TX    = 6;

  localparam logic [REG_W-1:0] FLAG_RST = 8'h14;
  localparam logic [REG_W-1:0] EN_RST   = 8'h80;

  typedef enum logic [SEL_W-1:0] {
    SEL_FLAGS  = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_idle_qual.sv
module evt_idle_qual (
  input  logic cmd_end,
  input  logic cmd_unknown,
  input  logic host_idle_cmd,
  output logic idle_ev
);
  // An idle entry that the host caused itself raises no flag.
  always_comb idle_ev = (cmd_end | cmd_unknown) & ~host_idle_cmd;
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int                 N       = 7,
  parameter logic [N-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         wr_hit,
  input  logic         wr_pol,
  input  logic [N-1:0] wr_mask,
  output logic [N-1:0] flags
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cell
      logic nxt;
      always_comb begin
        nxt = flags[g];
        if (wr_hit && wr_mask[g]) nxt = wr_pol;
        if (set_ev[g])            nxt = 1'b1;  // event outranks host clear
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[g] <= RST_VAL[g];
        else        flags[g] <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
  parameter int N = 7
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en_mask,
  input  logic         invert,
  output logic         req,
  output logic         pin
);
  always_comb begin
    req = |(flags & en_mask);
    pin = req ^ invert;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [REG_W-1:0]     rd_data,
  input  logic [NUM_FLAGS-1:0] evt_in,
  input  logic                 cmd_unknown,
  input  logic                 host_idle_cmd,
  output logic                 irq_pin
);
  logic [NUM_FLAGS-1:0] flags;
  logic [REG_W-1:0]     enables;
  logic [NUM_FLAGS-1:0] set_ev;
  logic                 idle_ev;
  logic                 req;
  logic                 flag_hit;

  evt_idle_qual u_idle (
    .cmd_end      (evt_in[BIT_IDLE]),
    .cmd_unknown  (cmd_unknown),
    .host_idle_cmd(host_idle_cmd),
    .idle_ev      (idle_ev)
  );

  always_comb begin
    set_ev           = evt_in;
    set_ev[BIT_IDLE] = idle_ev;
    flag_hit         = wr_en && (wr_sel == SEL_FLAGS);
  end

  evt_flag_bank #(
    .N      (NUM_FLAGS),
    .RST_VAL(FLAG_RST[NUM_FLAGS-1:0])
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (set_ev),
    .wr_hit (flag_hit),
    .wr_pol (wr_data[REG_W-1]),
    .wr_mask(wr_data[NUM_FLAGS-1:0]),
    .flags  (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             enables <= EN_RST;
    else if (wr_en && wr_sel == SEL_ENABLE) enables <= wr_data;
  end

  evt_irq_combine #(.N(NUM_FLAGS)) u_comb (
    .flags  (flags),
    .en_mask(enables[NUM_FLAGS-1:0]),
    .invert (enables[REG_W-1]),
    .req    (req),
    .pin    (irq_pin)
  );

  always_comb begin
    case (rd_sel)
      SEL_FLAGS:  rd_data = {1'b0, flags};
      SEL_ENABLE: rd_data = enables;
      SEL_STATUS: rd_data = {{(REG_W-1){1'b0}}, req};
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [6:0] evt_in,
  input logic       cmd_unknown,
  input logic       host_idle_cmd,
  input logic [6:0] flags,
  input logic [7:0] enables,
  input logic       irq_pin
);
  logic flag_wr;
  always_comb flag_wr = wr_en && (wr_sel == 2'd0);

  // R2: a non-idle event leaves its flag set after the edge
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(evt_in & 7'h6F)) == $past(evt_in & 7'h6F)));

  // R3: a set-write raises every marked flag
  p_set_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && wr_data[7]) |=> ((flags & $past(wr_data[6:0])) == $past(wr_data[6:0])));

  // R4: a clear-write with no events drops every marked flag
  p_clr_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !wr_data[7] && evt_in == 7'd0 && !cmd_unknown)
      |=> ((flags & $past(wr_data[6:0])) == 7'd0));

  // R5: a colliding event keeps its flag set despite the clear
  p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !wr_data[7])
      |=> ((flags & $past(wr_data[6:0] & evt_in & 7'h6F)) == $past(wr_data[6:0] & evt_in & 7'h6F)));

  // R7: pin polarity follows enable bit 7
  p_pin_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin == ((|(flags & enables[6:0])) ^ enables[7]));

  // R8: a host-issued idle never raises the idle flag
  p_host_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_idle_cmd && !flag_wr) |=> (flags[4] == $past(flags[4])));

  // R10: writes elsewhere leave the enable register alone
  p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd1) |=> $stable(enables));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .evt_in       (evt_in),
  .cmd_unknown  (cmd_unknown),
  .host_idle_cmd(host_idle_cmd),
  .flags        (flags),
  .enables      (enables),
  .irq_pin      (irq_pin)
);

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic [6:0] evt_in = 7'd0;
  logic       cmd_unknown = 1'b0;
  logic       host_idle_cmd = 1'b0;
  logic       irq_pin;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  evt_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_in(evt_in), .cmd_unknown(cmd_unknown),
    .host_idle_cmd(host_idle_cmd), .irq_pin(irq_pin)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] sel;
    logic [7:0] data;
    logic [6:0] evt;
    logic       unk;
    logic       hidle;
    logic [7:0] exp_flags;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 8'h7F, 7'h00, 1'b0, 1'b0, 8'h00, 4'd4},  // R4 clear all
    '{1'b0, 2'd0, 8'h00, 7'h01, 1'b0, 1'b0, 8'h01, 4'd2},  // R2 timer
    '{1'b0, 2'd0, 8'h00, 7'h60, 1'b0, 1'b0, 8'h61, 4'd2},  // R2 rx+tx
    '{1'b1, 2'd0, 8'h8A, 7'h00, 1'b0, 1'b0, 8'h6B, 4'd3},  // R3 set 1,3
    '{1'b1, 2'd0, 8'h41, 7'h00, 1'b0, 1'b0, 8'h2A, 4'd4},  // R4 clear 0,6
    '{1'b1, 2'd0, 8'h02, 7'h02, 1'b0, 1'b0, 8'h2A, 4'd5},  // R5 event beats clear
    '{1'b0, 2'd0, 8'h00, 7'h10, 1'b0, 1'b0, 8'h3A, 4'd8},  // R8 command end
    '{1'b1, 2'd0, 8'h10, 7'h00, 1'b0, 1'b0, 8'h2A, 4'd4},  // R4 clear idle
    '{1'b0, 2'd0, 8'h00, 7'h10, 1'b0, 1'b1, 8'h2A, 4'd8},  // R8 host idle suppressed
    '{1'b0, 2'd0, 8'h00, 7'h00, 1'b1, 1'b0, 8'h3A, 4'd8},  // R8 unknown command
    '{1'b1, 2'd0, 8'h7F, 7'h04, 1'b0, 1'b0, 8'h04, 4'd5},  // R5 clear-all vs low alert
    '{1'b1, 2'd0, 8'hFF, 7'h00, 1'b0, 1'b0, 8'h7F, 4'd9},  // R9 set all, bit 7 reads 0
    '{1'b1, 2'd2, 8'h00, 7'h00, 1'b0, 1'b0, 8'h7F, 4'd10}, // R10 write to status ignored
    '{1'b1, 2'd0, 8'h7F, 7'h00, 1'b0, 1'b0, 8'h00, 4'd4}   // R4 clear all again
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic step(input logic we, input logic [1:0] s, input logic [7:0] d,
                      input logic [6:0] e, input logic u, input logic h);
    @(negedge clk);
    wr_en = we; wr_sel = s; wr_data = d; evt_in = e; cmd_unknown = u; host_idle_cmd = h;
    @(posedge clk);
    #2;
    wr_en = 1'b0; evt_in = 7'd0; cmd_unknown = 1'b0; host_idle_cmd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #3;
    // R1 reset values
    rd(2'd0, v); check("R1 flags", v, 8'h14);
    rd(2'd1, v); check("R1 enable", v, 8'h80);
    rd(2'd2, v); check("R1 status", v, 8'h00);
    check("R1 pin", {7'd0, irq_pin}, 8'h01);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].we, TBL[i].sel, TBL[i].data, TBL[i].evt, TBL[i].unk, TBL[i].hidle);
      rd(2'd0, v);
      n_cmp++;
      if (v !== TBL[i].exp_flags) begin
        n_bad++;
        $display("FAIL R%0d vector %0d: actual %02h expected %02h",
                 TBL[i].req, i, v, TBL[i].exp_flags);
      end
    end
    rd(2'd1, v); check("R10 enable untouched by select 2 write", v, 8'h80);

    // R6 and R10: enable timer only, then raise the timer flag
    step(1'b1, 2'd1, 8'h01, 7'h00, 1'b0, 1'b0);
    rd(2'd1, v); check("R10 enable readback", v, 8'h01);
    rd(2'd2, v); check("R6 status no flag", v, 8'h00);
    step(1'b0, 2'd0, 8'h00, 7'h01, 1'b0, 1'b0);
    rd(2'd2, v); check("R6 status enabled flag", v, 8'h01);
    check("R7 pin non-inverted high", {7'd0, irq_pin}, 8'h01);
    // R6 masked: enable only the error flag
    step(1'b1, 2'd1, 8'h02, 7'h00, 1'b0, 1'b0);
    rd(2'd2, v); check("R6 status masked", v, 8'h00);
    check("R7 pin non-inverted low", {7'd0, irq_pin}, 8'h00);
    // R7 inverted
    step(1'b1, 2'd1, 8'h82, 7'h00, 1'b0, 1'b0);
    check("R7 pin inverted idle", {7'd0, irq_pin}, 8'h01);
    step(1'b1, 2'd1, 8'h81, 7'h00, 1'b0, 1'b0);
    check("R7 pin inverted active", {7'd0, irq_pin}, 8'h00);
    rd(2'd3, v); check("R6 select 3 reads zero", v, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule